// File: doc/BRIEF.md
# Protection Entry Register Bank with Granularity-Aware Readback

This block stores the per-entry settings of a physical memory protection unit. Each entry has an 8-bit configuration byte and a word-address register. The configuration byte holds read, write and execute permission bits, a 2-bit address-matching mode and a lock bit. Software reaches the bank through one port. An entry index selects the entry. Separate write strobes are given for the configuration byte and the address register. Read data is combinational from the selected index.

A fixed granularity parameter `G` sets the smallest protected region to 2^(G+2) bytes. Configuration writes are legalized against `G`: when `G` is 1 or more, the naturally aligned four-byte mode cannot be chosen. Address readback reports the granularity. The low address bits read back forced to zero or to one, depending on the entry's current mode. The stored bits are never altered by this forcing. Range matching and permission checking happen elsewhere and use these registers.

Top module: `pmp_csr_bank`

## Requirements
- R1: After reset every entry reads configuration 0x00 (mode OFF, lock clear) and address 0.
- R2: A configuration write to an unlocked entry takes effect on the next clock edge. The byte layout is: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode, bit 7 lock. Bits 6:5 always read 0.
- R3: The mode codes are 00 OFF, 01 TOR, 10 NA4 and 11 NAPOT. When G >= 1, a write that requests mode 10 keeps the entry's previous mode, while the other fields of the write are still applied.
- R4: An address write to an unlocked entry stores the low PLEN-2 bits of the write data on the next clock edge. Read data is zero-extended to XLEN bits.
- R5: When G >= 1 and mode bit 1 is clear (OFF or TOR), address read bits [G-1:0] are 0. With G=2 these are bits 1:0.
- R6: When G >= 2 and mode bit 1 is set, address read bits [G-2:0] are 1. With G=2 and NAPOT, bit 0 reads 1 whatever value is stored.
- R7: Stored address bits do not change when the mode changes. Switching the mode back restores the earlier readback.
- R8: An entry whose lock bit is set ignores both configuration and address writes until reset.
- R9: A write changes only the entry selected by the index. Reads return the selected entry combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_i | input | IDX_W | Entry index for read and write |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_wdata_i | input | 8 | Configuration byte write data |
| addr_we_i | input | 1 | Address register write strobe |
| addr_wdata_i | input | XLEN | Address register write data |
| cfg_rdata_o | output | 8 | Legalized configuration byte of the selected entry |
| addr_rdata_o | output | XLEN | Address of the selected entry with granularity forcing applied |

## Verification
The bench stores an address whose bit 1 is set and then moves the entry through NAPOT, TOR and back to NAPOT. A design that forced the wrong bit count, or that overwrote the stored bits instead of masking them on read, returns the wrong low bits on one of these reads. Requests for NA4 are made both from an OFF entry and from a NAPOT entry. A design that let NA4 through, or that fell back to a fixed mode, fails to keep the earlier mode. A locked entry is hit with configuration and address writes and then reset. A design that leaks writes past the lock, or that keeps the lock past reset, shows up at the ports.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_TOR   = 2'b01,
    MODE_NA4   = 2'b10,
    MODE_NAPOT = 2'b11
  } pmp_mode_e;

  typedef struct packed {
    logic      lock;
    logic [1:0] rsvd;
    pmp_mode_e mode;
    logic      x;
    logic      w;
    logic      r;
  } pmp_cfg_t;

endpackage

// File: rtl/pmp_cfg_legalize.sv
module pmp_cfg_legalize
  import pmp_csr_pkg::*;
#(
  parameter int G = 2
) (
  input  pmp_cfg_t   old_i,
  input  logic [7:0] wdata_i,
  output pmp_cfg_t   new_o
);

  always_comb begin
    new_o      = pmp_cfg_t'(wdata_i);
    new_o.rsvd = '0;
    // NA4 not selectable once regions exceed 4 bytes: keep previous mode
    if (G >= 1 && new_o.mode == MODE_NA4) new_o.mode = old_i.mode;
  end

endmodule

// File: rtl/pmp_addr_rdmask.sv
module pmp_addr_rdmask #(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 32,
  parameter int G      = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              napot_cls_i,
  output logic [XLEN-1:0]   rdata_o
);

  localparam int ZW = (G >= 1) ? G : 1;
  localparam int OW = (G >= 2) ? G - 1 : 1;

  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked = addr_i;
    if (G >= 2 && napot_cls_i)  masked[OW-1:0] = '1;
    if (G >= 1 && !napot_cls_i) masked[ZW-1:0] = '0;
    rdata_o = '0;
    rdata_o[ADDR_W-1:0] = masked;
  end

endmodule

// File: rtl/pmp_entry.sv
module pmp_entry
  import pmp_csr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int G      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  output pmp_cfg_t          cfg_o,
  output logic [ADDR_W-1:0] addr_o
);

  pmp_cfg_t          cfg_q, cfg_legal;
  logic [ADDR_W-1:0] addr_q;

  pmp_cfg_legalize #(.G(G)) u_legal (
    .old_i   (cfg_q),
    .wdata_i (cfg_wdata_i),
    .new_o   (cfg_legal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else if (!cfg_q.lock) begin
      if (sel_i && cfg_we_i)  cfg_q  <= cfg_legal;
      if (sel_i && addr_we_i) addr_q <= addr_wdata_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign addr_o = addr_q;

  p_lock_cfg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.lock |=> $stable(cfg_q));
  p_lock_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.lock |=> $stable(addr_q));
  p_addr_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && addr_we_i) |=> $stable(addr_q));
  p_cfg_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && cfg_we_i) |=> $stable(cfg_q));

  if (G >= 1) begin : g_na4_chk
    p_no_na4_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q.mode != MODE_NA4);
  end

endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
  import pmp_csr_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int XLEN        = 32,
  parameter int PLEN        = 34,
  parameter int G           = 2,
  localparam int ADDR_W     = PLEN - 2,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  input  logic             addr_we_i,
  input  logic [XLEN-1:0]  addr_wdata_i,
  output logic [7:0]       cfg_rdata_o,
  output logic [XLEN-1:0]  addr_rdata_o
);

  localparam int OW = (G >= 2) ? G - 1 : 1;
  localparam int ZW = (G >= 1) ? G : 1;

  pmp_cfg_t          cfg_arr  [NUM_ENTRIES];
  logic [ADDR_W-1:0] addr_arr [NUM_ENTRIES];
  pmp_cfg_t          cfg_sel;
  logic [ADDR_W-1:0] addr_sel;
  logic              idx_ok;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    pmp_entry #(.ADDR_W(ADDR_W), .G(G)) u_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sel_i        (idx_i == IDX_W'(i)),
      .cfg_we_i     (cfg_we_i),
      .cfg_wdata_i  (cfg_wdata_i),
      .addr_we_i    (addr_we_i),
      .addr_wdata_i (addr_wdata_i[ADDR_W-1:0]),
      .cfg_o        (cfg_arr[i]),
      .addr_o       (addr_arr[i])
    );
  end

  assign idx_ok = ({1'b0, idx_i} < (IDX_W + 1)'(NUM_ENTRIES));

  always_comb begin
    cfg_sel  = '0;
    addr_sel = '0;
    if (idx_ok) begin
      cfg_sel  = cfg_arr[idx_i];
      addr_sel = addr_arr[idx_i];
    end
  end

  pmp_addr_rdmask #(.ADDR_W(ADDR_W), .XLEN(XLEN), .G(G)) u_rdmask (
    .addr_i      (addr_sel),
    .napot_cls_i (cfg_sel.mode[1]),
    .rdata_o     (addr_rdata_o)
  );

  assign cfg_rdata_o = cfg_sel;

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[6:5] == 2'b00);

  if (G >= 2) begin : g_napot_chk
    p_napot_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_rdata_o[4] |-> (&addr_rdata_o[OW-1:0]));
  end

  if (G >= 1) begin : g_offtor_chk
    p_offtor_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_rdata_o[4] |-> (addr_rdata_o[ZW-1:0] == '0));
  end

endmodule

// File: tb/pmp_csr_bank_tb_top.sv
`timescale 1ns/1ps
module pmp_csr_bank_tb_top;

  localparam int N    = 8;
  localparam int XLEN = 32;
  localparam int PLEN = 34;
  localparam int G    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  idx = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wd = '0;
  logic        addr_we = 1'b0;
  logic [31:0] addr_wd = '0;
  logic [7:0]  cfg_rd;
  logic [31:0] addr_rd;

  logic [7:0]  m_cfg  [N];
  logic [31:0] m_addr [N];
  int    checks = 0;
  int    errors = 0;
  bit    cmp_en = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  pmp_csr_bank #(.NUM_ENTRIES(N), .XLEN(XLEN), .PLEN(PLEN), .G(G)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .addr_we_i(addr_we), .addr_wdata_i(addr_wd),
    .cfg_rdata_o(cfg_rd), .addr_rdata_o(addr_rd)
  );

  function automatic logic [7:0] legal_cfg(logic [7:0] old, logic [7:0] d);
    logic [7:0] v = d & 8'h9F;
    if (G >= 1 && v[4:3] == 2'b10) v[4:3] = old[4:3];
    return v;
  endfunction

  function automatic logic [31:0] exp_addr(logic [31:0] a, logic [7:0] c);
    logic [31:0] r = a;
    if (c[4]) begin
      for (int b = 0; b < G - 1; b++) r[b] = 1'b1;
    end else begin
      for (int b = 0; b < G; b++) r[b] = 1'b0;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check(cur_req, {24'h0, cfg_rd}, {24'h0, m_cfg[idx]});
      check(cur_req, addr_rd, exp_addr(m_addr[idx], m_cfg[idx]));
    end
  end

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_cfg[i]  = '0;
      m_addr[i] = '0;
    end
  endtask

  task automatic wr_cfg(int i, logic [7:0] d);
    @(posedge clk); #1;
    idx = 3'(i); cfg_we = 1'b1; cfg_wd = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (!m_cfg[i][7]) m_cfg[i] = legal_cfg(m_cfg[i], d);
  endtask

  task automatic wr_addr(int i, logic [31:0] d);
    @(posedge clk); #1;
    idx = 3'(i); addr_we = 1'b1; addr_wd = d;
    @(posedge clk); #1;
    addr_we = 1'b0;
    if (!m_cfg[i][7]) m_addr[i] = d;
  endtask

  task automatic sel(int i);
    @(posedge clk); #1;
    idx = 3'(i);
    @(negedge clk); #0.5;
  endtask

  task automatic sweep();
    for (int i = 0; i < N; i++) sel(i);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_en = 1'b1;

    cur_req = "R1";
    sweep();
    sel(4);
    check("R1", {24'h0, cfg_rd}, 32'h0);
    check("R1", addr_rd, 32'h0);

    cur_req = "R4";
    for (int i = 0; i < N; i++) wr_addr(i, 32'h1000_0000 + i * 32'h0101_0101 + i);
    sweep();
    sel(3);
    check("R4", addr_rd, 32'h1303_0304);   // stored ...06, OFF clears 1:0

    cur_req = "R5";
    wr_addr(5, 32'hDEAD_BEEE);
    sel(5);
    check("R5", addr_rd, 32'hDEAD_BEEC);

    cur_req = "R2";
    wr_cfg(5, 8'h7F);
    sel(5);
    check("R2", {24'h0, cfg_rd}, 32'h1F);
    cur_req = "R6";
    check("R6", addr_rd, 32'hDEAD_BEEF);

    cur_req = "R3";
    wr_cfg(5, 8'h12);
    sel(5);
    check("R3", {24'h0, cfg_rd}, 32'h1A);
    wr_cfg(6, 8'h10);
    sel(6);
    check("R3", {24'h0, cfg_rd}, 32'h00);

    cur_req = "R7";
    wr_cfg(5, 8'h0B);
    sel(5);
    check("R7", addr_rd, 32'hDEAD_BEEC);
    check("R7", {24'h0, cfg_rd}, 32'h0B);
    wr_cfg(5, 8'h18);
    sel(5);
    check("R7", addr_rd, 32'hDEAD_BEEF);

    cur_req = "R9";
    wr_cfg(2, 8'h09);
    sweep();
    sel(1);
    check("R9", {24'h0, cfg_rd}, 32'h00);

    cur_req = "R8";
    wr_cfg(3, 8'h9B);
    wr_cfg(3, 8'h00);
    wr_addr(3, 32'h0000_0000);
    sel(3);
    check("R8", {24'h0, cfg_rd}, 32'h9B);
    check("R8", addr_rd, 32'h1303_0307);
    sweep();

    cur_req = "R1";
    @(posedge clk); #1;
    rst_n = 1'b0;
    model_clear();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    sel(3);
    check("R1", {24'h0, cfg_rd}, 32'h00);
    check("R1", addr_rd, 32'h0);
    cur_req = "R8";
    wr_addr(3, 32'h0000_0055);
    sel(3);
    check("R8", addr_rd, 32'h0000_0054);
    sweep();

    cmp_en = 1'b0;
    summary();
    $finish;
  end

endmodule